// File: doc/BRIEF.md
# Interrupt Redirection and Service Engine

This block routes a set of interrupt input pins to delivery messages. Each pin owns a programmable redirection entry that selects polarity, trigger style, masking, target and vector. Input levels are conditioned by the entry's polarity and trigger style into a pending bit per pin. The engine then continuously picks pending, unmasked pins and emits one delivery message per pick on a valid/ready output. For pins whose delivery mode is the legacy encoding, it first fetches the vector from an external legacy controller over a request/acknowledge pair.

Level-triggered pins carry an in-service flag. The flag is set when the pin is delivered, and it holds the pin back until an end-of-interrupt notice names that pin's vector. If the pin is still asserted after the notice, it is delivered again. Input 0 is folded onto input 2, so a request on pin 0 is handled through entry 2. A table write port lets the surrounding register logic replace whole entries, and every write causes the pins to be evaluated again.

Top module: `irq_route_engine`

Entry layout with default widths (VEC_W=8, DM_W=3, DEST_W=8, 23 bits): vector [7:0], delivery mode [10:8], destination mode [11], polarity-invert [12], trigger [13] (1 = level, 0 = edge), mask [14] (1 = masked), destination [22:15].

## Requirements
- R1: After reset every entry reads as masked (bit 14 set, all other bits zero), every pending bit and in-service flag is clear, and neither dlv_valid nor fetch_req is asserted, even while pins toggle.
- R2: A request on pin 0 is handled as a request on pin 2 (pin 0 OR pin 2, conditioned by entry 2). Entry 0 never produces a delivery.
- R3: When polarity bit 12 is set, the pin level is inverted before any other processing. For a level entry (bit 13 = 1), the pending bit follows the conditioned level: it is set while the level is active and cleared when it goes inactive.
- R4: For an edge entry (bit 13 = 0), a rising conditioned level sets the pending bit only if mask bit 14 is clear. Edges that arrive while the entry is masked are discarded, so unmasking the entry later does not deliver them.
- R5: A delivery carries the entry's destination [22:15] on dlv_dest, destination mode [11] on dlv_dest_mode, delivery mode [10:8] on dlv_mode, trigger [13] on dlv_level, and vector [7:0] on dlv_vector.
- R6: Delivering an edge pin clears its pending bit, so one edge yields exactly one message, even if the level stays high.
- R7: Delivering a level pin sets its in-service flag and leaves its pending bit alone. While the flag is set, the pin is not delivered again.
- R8: An end-of-interrupt notice clears the in-service flag of every entry whose flag is set and whose vector equals eoi_vector. If such an entry is unmasked and still pending, it is delivered again. A notice with any other vector has no effect.
- R9: When the delivery mode equals the legacy code (default 3'b111), fetch_req is raised and held until fetch_ack. The message then carries fetch_vector in place of the entry vector.
- R10: A table write takes effect on the next cycle. A pending pin that the write unmasks is delivered without a new input event.
- R11: Pending pins are serviced lowest index first. At most one message is accepted per clock, and back-to-back messages are possible when dlv_ready stays high.
- R12: While dlv_valid is high and dlv_ready is low, dlv_valid and every payload field hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Raw interrupt pin levels |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_data | input | ENTRY_W | New entry contents |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | VEC_W | Vector named by the notice |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery sink ready |
| dlv_dest | output | DEST_W | Message destination |
| dlv_dest_mode | output | 1 | Message destination mode |
| dlv_mode | output | DM_W | Message delivery mode |
| dlv_vector | output | VEC_W | Message vector |
| dlv_level | output | 1 | Message trigger (1 = level) |
| fetch_req | output | 1 | Legacy vector fetch request |
| fetch_ack | input | 1 | Legacy vector fetch acknowledge |
| fetch_vector | input | VEC_W | Vector returned by the legacy controller |

## Verification
The bench goes after several corner cases. One is an edge that arrives while its entry is masked: a design that latches it would deliver a stale interrupt as soon as the entry is unmasked. Another is a level pin held active across its delivery: a design without the in-service hold would flood the output, and one that ignores the vector match would re-deliver on the wrong end-of-interrupt notice. The bench also folds pin 0 onto entry 2, fetches legacy vectors under a randomly slow acknowledge, and stalls the output while two pins wait, where a wrong arbiter or a payload that changes under stall would surface as misordered or corrupted messages. Randomly programmed tables and pins are compared cycle by cycle against a reference model built from the requirements.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   // Service sequencer states
   typedef enum logic [1:0] {
      SVC_IDLE  = 2'd0,
      SVC_FETCH = 2'd1,
      SVC_SEND  = 2'd2
   } svc_state_e;

   // Entry field positions, derived from the field widths
   function automatic int mode_lsb(input int vec_w);
      return vec_w;
   endfunction

   function automatic int dmode_bit(input int vec_w, input int dm_w);
      return vec_w + dm_w;
   endfunction

   function automatic int pol_bit(input int vec_w, input int dm_w);
      return vec_w + dm_w + 1;
   endfunction

   function automatic int trig_bit(input int vec_w, input int dm_w);
      return vec_w + dm_w + 2;
   endfunction

   function automatic int mask_bit(input int vec_w, input int dm_w);
      return vec_w + dm_w + 3;
   endfunction

   function automatic int dest_lsb(input int vec_w, input int dm_w);
      return vec_w + dm_w + 4;
   endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int  N          = 8,
   parameter bit  USE_ARITH  = 1'b1,
   localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);

   generate
      if (USE_ARITH) begin : g_arith
         // isolate the lowest set bit with a two's complement trick
         assign gnt = req & (~req + N'(1));
      end else begin : g_scan
         always_comb begin
            logic seen;
            seen = 1'b0;
            gnt  = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !seen) begin
                  gnt[i] = 1'b1;
                  seen   = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) idx = idx | IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
   parameter int N     = 8,
   parameter bit ALIAS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_level,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] trig,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] clr_edge,
   output logic [N-1:0] pend
);

   logic [N-1:0] cond;
   logic [N-1:0] prev_q;
   logic [N-1:0] pend_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_pin
         if (ALIAS && i == 0) begin : g_dead
            assign cond[i] = pol[i] & 1'b0;
         end else if (ALIAS && i == 2) begin : g_merge
            assign cond[i] = (pin_level[0] | pin_level[2]) ^ pol[i];
         end else begin : g_plain
            assign cond[i] = pin_level[i] ^ pol[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= cond;
         for (int i = 0; i < N; i++) begin
            if (trig[i]) begin
               pend_q[i] <= cond[i];
            end else begin
               pend_q[i] <= (pend_q[i] & ~clr_edge[i]) |
                            (cond[i] & ~prev_q[i] & ~mask[i]);
            end
         end
      end
   end

   assign pend = pend_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         // R4
         masked_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pend_q[i]) && $past(!trig[i])) |-> $past(!mask[i]));
      end
      if (ALIAS) begin : g_alias_chk
         // R2
         alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pend_q[0]);
      end
   endgenerate

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table #(
   parameter int N       = 8,
   parameter int VEC_W   = 8,
   parameter int ENTRY_W = 23,
   parameter int MASK_B  = 14,
   parameter int IW      = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IW-1:0]               widx,
   input  logic [ENTRY_W-1:0]          wdata,
   input  logic                        eoi_valid,
   input  logic [VEC_W-1:0]            eoi_vector,
   input  logic [N-1:0]                set_rem,
   output logic [N-1:0][ENTRY_W-1:0]   entries,
   output logic [N-1:0]                rem
);

   localparam logic [ENTRY_W-1:0] RESET_ENTRY = ENTRY_W'(1) << MASK_B;

   logic [N-1:0][ENTRY_W-1:0] ent_q;
   logic [N-1:0]              rem_q;
   logic [N-1:0]              eoi_hit;

   generate
      for (genvar i = 0; i < N; i++) begin : g_hit
         assign eoi_hit[i] = eoi_valid && rem_q[i] &&
                             (ent_q[i][VEC_W-1:0] == eoi_vector);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) ent_q[i] <= RESET_ENTRY;
         rem_q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (we && (widx == IW'(i))) ent_q[i] <= wdata;
         end
         rem_q <= (rem_q & ~eoi_hit) | set_rem;
      end
   end

   assign entries = ent_q;
   assign rem     = rem_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         // R8
         eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_valid && rem_q[i] && (ent_q[i][VEC_W-1:0] == eoi_vector))
            |=> !rem_q[i]);
      end
   endgenerate

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
   import irq_route_pkg::*;
#(
   parameter int                 NUM_PINS    = 8,
   parameter int                 VEC_W       = 8,
   parameter int                 DM_W        = 3,
   parameter int                 DEST_W      = 8,
   parameter logic [DM_W-1:0]    LEGACY_MODE = '1,
   parameter bit                 ALIAS_PIN0  = 1'b1,
   parameter bit                 PICK_ARITH  = 1'b1,
   localparam int                IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int                ENTRY_W     = VEC_W + DM_W + DEST_W + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pin_level,
   input  logic                 tbl_we,
   input  logic [IDX_W-1:0]     tbl_idx,
   input  logic [ENTRY_W-1:0]   tbl_data,
   input  logic                 eoi_valid,
   input  logic [VEC_W-1:0]     eoi_vector,
   output logic                 dlv_valid,
   input  logic                 dlv_ready,
   output logic [DEST_W-1:0]    dlv_dest,
   output logic                 dlv_dest_mode,
   output logic [DM_W-1:0]      dlv_mode,
   output logic [VEC_W-1:0]     dlv_vector,
   output logic                 dlv_level,
   output logic                 fetch_req,
   input  logic                 fetch_ack,
   input  logic [VEC_W-1:0]     fetch_vector
);

   localparam int M_LSB  = mode_lsb(VEC_W);
   localparam int DM_B   = dmode_bit(VEC_W, DM_W);
   localparam int POL_B  = pol_bit(VEC_W, DM_W);
   localparam int TRIG_B = trig_bit(VEC_W, DM_W);
   localparam int MASK_B = mask_bit(VEC_W, DM_W);
   localparam int D_LSB  = dest_lsb(VEC_W, DM_W);

   // elaboration-time parameter checks
   generate
      if (ALIAS_PIN0 && NUM_PINS < 3) begin : g_bad_alias
         $error("pin folding needs at least three pins");
      end
      if (NUM_PINS < 2) begin : g_bad_pins
         $error("NUM_PINS must be at least 2");
      end
      if (VEC_W < 1 || DM_W < 1 || DEST_W < 1) begin : g_bad_width
         $error("field widths must be positive");
      end
   endgenerate

   // table
   logic [NUM_PINS-1:0][ENTRY_W-1:0] entries;
   logic [NUM_PINS-1:0]              rem;
   logic [NUM_PINS-1:0]              set_rem;
   logic [NUM_PINS-1:0]              clr_edge;

   irq_redir_table #(
      .N       (NUM_PINS),
      .VEC_W   (VEC_W),
      .ENTRY_W (ENTRY_W),
      .MASK_B  (MASK_B),
      .IW      (IDX_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (tbl_we),
      .widx       (tbl_idx),
      .wdata      (tbl_data),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .set_rem    (set_rem),
      .entries    (entries),
      .rem        (rem)
   );

   // per-pin field slices
   logic [NUM_PINS-1:0] pol, trig, mask;

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_fld
         assign pol[i]  = entries[i][POL_B];
         assign trig[i] = entries[i][TRIG_B];
         assign mask[i] = entries[i][MASK_B];
      end
   endgenerate

   // input conditioning
   logic [NUM_PINS-1:0] pend;

   irq_pin_front #(
      .N     (NUM_PINS),
      .ALIAS (ALIAS_PIN0)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_level (pin_level),
      .pol       (pol),
      .trig      (trig),
      .mask      (mask),
      .clr_edge  (clr_edge),
      .pend      (pend)
   );

   // selection
   logic [NUM_PINS-1:0] elig;
   logic [NUM_PINS-1:0] gnt;
   logic [IDX_W-1:0]    sel_idx;
   logic                sel_any;

   assign elig = pend & ~mask & ~(trig & rem);

   irq_lowest_pick #(
      .N         (NUM_PINS),
      .USE_ARITH (PICK_ARITH)
   ) u_pick (
      .req (elig),
      .gnt (gnt),
      .idx (sel_idx),
      .any (sel_any)
   );

   // service sequencer
   svc_state_e          state_q;
   logic [DEST_W-1:0]   m_dest;
   logic                m_dmode;
   logic [DM_W-1:0]     m_mode;
   logic [VEC_W-1:0]    m_vec;
   logic                m_level;
   logic                can_load;
   logic                load;
   logic [ENTRY_W-1:0]  sel_entry;
   logic                sel_legacy;

   assign can_load   = (state_q == SVC_IDLE) || ((state_q == SVC_SEND) && dlv_ready);
   assign load       = can_load && sel_any;
   assign sel_entry  = entries[sel_idx];
   assign sel_legacy = (sel_entry[M_LSB +: DM_W] == LEGACY_MODE);
   assign set_rem    = load ? (gnt & trig)  : '0;
   assign clr_edge   = load ? (gnt & ~trig) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SVC_IDLE;
         m_dest  <= '0;
         m_dmode <= 1'b0;
         m_mode  <= '0;
         m_vec   <= '0;
         m_level <= 1'b0;
      end else if (load) begin
         m_dest  <= sel_entry[D_LSB +: DEST_W];
         m_dmode <= sel_entry[DM_B];
         m_mode  <= sel_entry[M_LSB +: DM_W];
         m_vec   <= sel_entry[VEC_W-1:0];
         m_level <= sel_entry[TRIG_B];
         state_q <= sel_legacy ? SVC_FETCH : SVC_SEND;
      end else if ((state_q == SVC_FETCH) && fetch_ack) begin
         m_vec   <= fetch_vector;
         state_q <= SVC_SEND;
      end else if ((state_q == SVC_SEND) && dlv_ready) begin
         state_q <= SVC_IDLE;
      end
   end

   assign dlv_valid     = (state_q == SVC_SEND);
   assign fetch_req     = (state_q == SVC_FETCH);
   assign dlv_dest      = m_dest;
   assign dlv_dest_mode = m_dmode;
   assign dlv_mode      = m_mode;
   assign dlv_vector    = m_vec;
   assign dlv_level     = m_level;

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector) &&
         $stable(dlv_dest) && $stable(dlv_mode) && $stable(dlv_level) &&
         $stable(dlv_dest_mode)));

   // R9
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && !dlv_valid));

   // R9
   fetch_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ack) |=> (dlv_valid && (dlv_vector == $past(fetch_vector))));

endmodule

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb;

   localparam int N  = 8;
   localparam int VW = 8;
   localparam int EW = 23;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  pin_level;
   logic          tbl_we;
   logic [2:0]    tbl_idx;
   logic [EW-1:0] tbl_data;
   logic          eoi_valid;
   logic [VW-1:0] eoi_vector;
   logic          dlv_valid;
   logic          dlv_ready;
   logic [7:0]    dlv_dest;
   logic          dlv_dest_mode;
   logic [2:0]    dlv_mode;
   logic [VW-1:0] dlv_vector;
   logic          dlv_level;
   logic          fetch_req;
   logic          fetch_ack;
   logic [VW-1:0] fetch_vector;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  rand_ack = 1'b0;
   bit  rand_fvec = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   irq_route_engine #(
      .NUM_PINS (N), .VEC_W (VW), .DM_W (3), .DEST_W (8)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .pin_level (pin_level),
      .tbl_we (tbl_we), .tbl_idx (tbl_idx), .tbl_data (tbl_data),
      .eoi_valid (eoi_valid), .eoi_vector (eoi_vector),
      .dlv_valid (dlv_valid), .dlv_ready (dlv_ready), .dlv_dest (dlv_dest),
      .dlv_dest_mode (dlv_dest_mode), .dlv_mode (dlv_mode),
      .dlv_vector (dlv_vector), .dlv_level (dlv_level),
      .fetch_req (fetch_req), .fetch_ack (fetch_ack), .fetch_vector (fetch_vector)
   );

   // entry layout: dest[22:15] mask[14] trig[13] pol[12] dmode[11] mode[10:8] vec[7:0]
   function automatic logic [EW-1:0] mk_entry(input logic [7:0] vec, input logic [2:0] mode,
      input logic dmode, input logic pol, input logic trig, input logic msk, input logic [7:0] dest);
      return {dest, msk, trig, pol, dmode, mode, vec};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // reference model, built from the requirements
   logic [EW-1:0] m_tbl [N];
   logic [N-1:0]  m_pend, m_rem, m_prev;
   int            m_st;
   logic [EW-1:0] m_msg;
   logic [VW-1:0] m_vec;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) m_tbl[i] = 23'h004000;
         m_pend = '0; m_rem = '0; m_prev = '0; m_st = 0; m_msg = '0; m_vec = '0;
      end else begin
         logic [N-1:0] cond, elig, pn, rn;
         int sel;
         bit ld;
         for (int i = 0; i < N; i++) begin
            logic raw;
            raw = (i == 2) ? (pin_level[0] | pin_level[2]) : pin_level[i];
            cond[i] = (i == 0) ? 1'b0 : (raw ^ m_tbl[i][12]);
            elig[i] = m_pend[i] & ~m_tbl[i][14] & ~(m_tbl[i][13] & m_rem[i]);
         end
         sel = -1;
         for (int i = N - 1; i >= 0; i--) if (elig[i]) sel = i;
         ld = (sel >= 0) && (m_st == 0 || (m_st == 2 && dlv_ready));
         for (int i = 0; i < N; i++) begin
            bit picked;
            picked = ld && (sel == i);
            if (m_tbl[i][13]) pn[i] = cond[i];
            else pn[i] = (m_pend[i] & ~picked) | (cond[i] & ~m_prev[i] & ~m_tbl[i][14]);
            rn[i] = m_rem[i];
            if (eoi_valid && m_rem[i] && m_tbl[i][7:0] == eoi_vector) rn[i] = 1'b0;
            if (picked && m_tbl[i][13]) rn[i] = 1'b1;
         end
         if (ld) begin
            m_msg = m_tbl[sel];
            m_vec = m_tbl[sel][7:0];
            m_st  = (m_tbl[sel][10:8] == 3'd7) ? 1 : 2;
         end else if (m_st == 1 && fetch_ack) begin
            m_vec = fetch_vector;
            m_st  = 2;
         end else if (m_st == 2 && dlv_ready) begin
            m_st = 0;
         end
         if (tbl_we) m_tbl[tbl_idx] = tbl_data;
         m_pend = pn; m_rem = rn; m_prev = cond;
      end
   end

   // cycle compare against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 valid", {31'd0, dlv_valid}, {31'd0, m_st == 2});
         chk("R9 fetch_req", {31'd0, fetch_req}, {31'd0, m_st == 1});
         if (dlv_valid && m_st == 2) begin
            chk("R5 vector", {24'd0, dlv_vector}, {24'd0, m_vec});
            chk("R5 dest", {24'd0, dlv_dest}, {24'd0, m_msg[22:15]});
            chk("R5 fields", {27'd0, dlv_dest_mode, dlv_mode, dlv_level},
                {27'd0, m_msg[11], m_msg[10:8], m_msg[13]});
         end
      end
   end

   // legacy controller responder
   always @(negedge clk) begin
      if (rand_fvec) fetch_vector = 8'($urandom);
      if (rand_ack) fetch_ack = fetch_req & ($urandom % 2 == 0);
      else fetch_ack = fetch_req;
   end

   task automatic write_entry(input int idx, input logic [EW-1:0] d);
      tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_data = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic send_eoi(input logic [7:0] v);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] m);
      pin_level = pin_level | m;
      repeat (2) @(negedge clk);
      pin_level = pin_level & ~m;
   endtask

   task automatic expect_msg(input string tag, input logic [7:0] v);
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 12 && !seen; k++) begin
         if (dlv_valid) begin
            chk(tag, {24'd0, dlv_vector}, {24'd0, v});
            seen = 1'b1;
         end
         @(negedge clk);
      end
      if (!seen) chk({tag, " no message"}, 32'd0, {24'd0, v});
   endtask

   task automatic expect_none(input string tag, input int n);
      bit hit;
      hit = 1'b0;
      for (int k = 0; k < n; k++) begin
         if (dlv_valid) hit = 1'b1;
         @(negedge clk);
      end
      chk(tag, {31'd0, hit}, 32'd0);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; pin_level = '0; tbl_we = 1'b0; tbl_idx = '0; tbl_data = '0;
      eoi_valid = 1'b0; eoi_vector = '0; dlv_ready = 1'b1; fetch_ack = 1'b0;
      fetch_vector = 8'hC3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: quiet after reset, all entries masked
      chk("R1 valid after reset", {31'd0, dlv_valid}, 32'd0);
      chk("R1 fetch after reset", {31'd0, fetch_req}, 32'd0);
      pin_level = 8'hFF;
      expect_none("R1 masked pins", 8);
      pin_level = 8'h00;
      expect_none("R1 masked release", 4);

      // R5/R6: edge entry, one message per edge
      write_entry(3, mk_entry(8'h33, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A));
      pin_level[3] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 dest", {24'd0, dlv_dest}, 32'h5A);
      chk("R5 dest mode", {31'd0, dlv_dest_mode}, 32'd1);
      chk("R5 level flag", {31'd0, dlv_level}, 32'd0);
      expect_msg("R5 edge vector", 8'h33);
      expect_none("R6 held edge no repeat", 6);
      pin_level[3] = 1'b0;

      // R4: edge on masked entry discarded
      write_entry(5, mk_entry(8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01));
      pulse(8'h20);
      write_entry(5, mk_entry(8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
      expect_none("R4 masked edge dropped", 6);

      // R2: pin 0 folded onto entry 2
      write_entry(2, mk_entry(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02));
      write_entry(0, mk_entry(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
      pulse(8'h01);
      expect_msg("R2 alias vector", 8'h22);
      expect_none("R2 single message", 4);

      // R3/R7/R8: inverted level entry
      write_entry(6, mk_entry(8'h66, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h06));
      expect_msg("R3 inverted level", 8'h66);
      expect_none("R7 held until EOI", 6);
      send_eoi(8'h66);
      expect_msg("R8 redelivery", 8'h66);
      pin_level[6] = 1'b1;
      @(negedge clk);
      send_eoi(8'h66);
      expect_none("R3 deasserted level", 6);

      // R8: vector match
      write_entry(7, mk_entry(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07));
      pin_level[7] = 1'b1;
      expect_msg("R7 level deliver", 8'h77);
      send_eoi(8'h76);
      expect_none("R8 wrong vector ignored", 6);
      send_eoi(8'h77);
      expect_msg("R8 matching EOI", 8'h77);
      pin_level[7] = 1'b0;
      @(negedge clk);
      send_eoi(8'h77);
      expect_none("R8 idle after release", 4);

      // R9: legacy vector fetch
      write_entry(1, mk_entry(8'h11, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03));
      pulse(8'h02);
      chk("R9 legacy mode", {29'd0, dlv_mode}, 32'd7);
      expect_msg("R9 fetched vector", 8'hC3);

      // R10: write unmasks a pending level pin
      write_entry(4, mk_entry(8'h44, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04));
      pin_level[4] = 1'b1;
      expect_none("R10 masked level", 6);
      write_entry(4, mk_entry(8'h44, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04));
      expect_msg("R10 write rescans", 8'h44);
      pin_level[4] = 1'b0;
      @(negedge clk);
      send_eoi(8'h44);
      expect_none("R10 clean", 4);

      // R11/R12: ordering, stall, back-to-back
      dlv_ready = 1'b0;
      pulse(8'h0C);
      repeat (3) @(negedge clk);
      chk("R12 held valid", {31'd0, dlv_valid}, 32'd1);
      chk("R11 lowest first", {24'd0, dlv_vector}, 32'h22);
      dlv_ready = 1'b1;
      @(negedge clk);
      chk("R11 back-to-back valid", {31'd0, dlv_valid}, 32'd1);
      chk("R11 second vector", {24'd0, dlv_vector}, 32'h33);
      @(negedge clk);

      // constrained random phase
      rand_ack = 1'b1; rand_fvec = 1'b1;
      for (int c = 0; c < 4000; c++) begin
         for (int b = 0; b < N; b++) if ($urandom % 8 == 0) pin_level[b] = ~pin_level[b];
         tbl_we = ($urandom % 16 == 0);
         tbl_idx = 3'($urandom);
         tbl_data = mk_entry(8'h20 + 8'($urandom % 8), 3'($urandom), 1'($urandom), 1'($urandom),
                             1'($urandom), ($urandom % 4 == 0), 8'($urandom));
         eoi_valid = ($urandom % 8 == 0);
         eoi_vector = 8'h20 + 8'($urandom % 8);
         dlv_ready = ($urandom % 4 != 0);
         @(negedge clk);
      end
      tbl_we = 1'b0; eoi_valid = 1'b0;
      finish_run();
   end

endmodule